// File: doc/BRIEF.md
# Serial-Programmed Control Register Bank

This block lets a host processor program and inspect a bank of 24-bit control registers over a four-wire serial link. The wires are a serial clock, serial data in, serial data out and a select that is active high. Every transaction is a fixed frame of 32 bit-periods, sent most significant bit first. The first bit is a direction flag, where 1 means write and 0 means read. Six address bits follow, then one separator bit that carries no meaning, then 24 data bits. The register contents are also presented side by side on a wide parallel output, so the logic they control can use them directly.

All logic runs on one fast system clock. The three serial inputs are passed through a synchronizer, and the serial clock's edges are found by comparing successive synchronized samples. Input bits are taken on rising serial-clock edges. The output bit changes after each falling edge, so the host can sample it on the next rising edge. A write takes effect only when the 32nd bit arrives. Any frame cut short by select dropping is thrown away. Addresses at or above the number of built registers read back zero and ignore writes.

Top module: `spi_ctl_regfile`

## Requirements
- R1: After synchronous reset every register reads zero, `reg_flat` is all zero and `spi_miso_oe` is low.
- R2: `spi_miso_oe` is high while select is high and low while select is low; while it is low `spi_miso` is high-impedance.
- R3: A complete frame whose first bit is 1 writes the last 24 bits into the register named by bits 1 to 6 (address most significant bit first). Register n occupies bits [24n+23:24n] of `reg_flat`.
- R4: In a frame whose first bit is 0, `spi_miso` presents the addressed register's 24 bits, most significant bit first, across bit-periods 8 to 31. Each bit is valid at that period's rising serial-clock edge, and no register changes.
- R5: During bit-periods 0 to 7 of a frame (flag, address and separator), `spi_miso` drives 0.
- R6: The value of bit 7 (the separator) has no effect on the address or data of the frame.
- R7: A frame in which select falls before the 32nd rising edge changes no register, even if only the last bit is missing. The next frame, after select goes low then high, is decoded normally.
- R8: Rising serial-clock edges beyond the 32nd, while select stays high, are ignored.
- R9: Addresses at or above IMPL_REGS (default 48) read back zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is synchronous to it |
| rst | input | 1 | Synchronous reset, active high |
| spi_clk | input | 1 | Serial clock from the host |
| spi_sel | input | 1 | Frame select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, high-impedance when not selected |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| reg_flat | output | IMPL_REGS*DATA_W | All implemented registers, register n at bits [DATA_W*n +: DATA_W] |

## Verification
The hidden state here is the bit counter, the latched direction flag and address, and the output shift buffer. If any of them is wrong, the fault shows up within the same frame. A misplaced count or address makes the bits on `spi_miso` slip or come from the wrong register. It also lands a write on the wrong `reg_flat` slice, which is visible one system clock after the 32nd rising edge. The bench therefore compares each read frame bit by bit against a model and compares the whole of `reg_flat` after every frame. Stray writes to unimplemented or aborted addresses are caught that way as well.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  typedef enum logic [2:0] {
    PH_FLAG,
    PH_ADDR,
    PH_DEAD,
    PH_DATA,
    PH_DONE
  } phase_e;

  // idx is the index of the next bit to be received in the frame
  function automatic phase_e phase_of(input int idx, input int aw, input int dw);
    if (idx == 0)            return PH_FLAG;
    if (idx <= aw)           return PH_ADDR;
    if (idx == aw + 1)       return PH_DEAD;
    if (idx < aw + 2 + dw)   return PH_DATA;
    return PH_DONE;
  endfunction

endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] sync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], raw[b]};
    end
    assign sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_ctl_frame.sv
module spi_ctl_frame
  import spi_ctl_pkg::*;
#(
  parameter  int ADDR_W    = 6,
  parameter  int DATA_W    = 24,
  localparam int FRAME_LEN = ADDR_W + DATA_W + 2,
  localparam int CNT_W     = $clog2(FRAME_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_s,
  input  logic              mosi_s,
  input  logic              sclk_s,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] rdata,
  output logic              wr_en,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              miso_q,
  output logic              miso_oe,
  output logic [CNT_W-1:0]  bit_cnt
);

  localparam int SR_W = DATA_W - 1;

  logic              sclk_prev;
  logic              sclk_rise;
  logic              sclk_fall;
  logic [SR_W-1:0]   sreg;
  logic              wr_flag;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] obuf;
  logic              take;
  phase_e            ph;

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;
  assign ph        = phase_of(int'(bit_cnt), ADDR_W, DATA_W);
  assign take      = sel_s && sclk_rise && (ph != PH_DONE);

  // address completes with the incoming bit when bit_cnt == ADDR_W
  assign raddr = {sreg[ADDR_W-2:0], mosi_s};
  assign waddr = addr_q;
  assign wdata = {sreg[SR_W-1:0], mosi_s};
  assign wr_en = take && wr_flag && (bit_cnt == CNT_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  always_ff @(posedge clk) begin
    if (rst || !sel_s) begin
      bit_cnt <= '0;
      sreg    <= '0;
      wr_flag <= 1'b0;
      addr_q  <= '0;
      obuf    <= '0;
      miso_q  <= 1'b0;
    end else if (take) begin
      sreg    <= {sreg[SR_W-2:0], mosi_s};
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(ADDR_W)) begin
        wr_flag <= sreg[ADDR_W-1];
        addr_q  <= raddr;
        obuf    <= rdata;
      end
    end else if (sclk_fall) begin
      if (ph == PH_DATA) begin
        miso_q <= obuf[DATA_W-1];
        obuf   <= {obuf[DATA_W-2:0], 1'b0};
      end else begin
        miso_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) miso_oe <= 1'b0;
    else     miso_oe <= sel_s;
  end

endmodule

// File: rtl/spi_ctl_bank.sv
module spi_ctl_bank #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 24,
  parameter int IMPL_REGS = 48
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           waddr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [ADDR_W-1:0]           raddr,
  output logic [DATA_W-1:0]           rdata,
  output logic [IMPL_REGS*DATA_W-1:0] reg_flat
);

  logic [DATA_W-1:0] regs [IMPL_REGS];

  for (genvar i = 0; i < IMPL_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                  regs[i] <= '0;
      else if (wr_en && waddr == ADDR_W'(i))    regs[i] <= wdata;
    end
    assign reg_flat[i*DATA_W +: DATA_W] = regs[i];
  end

  // unimplemented addresses fall through to zero
  always_comb begin
    rdata = '0;
    for (int i = 0; i < IMPL_REGS; i++) begin
      if (raddr == ADDR_W'(i)) rdata = regs[i];
    end
  end

endmodule

// File: rtl/spi_ctl_regfile.sv
module spi_ctl_regfile #(
  parameter  int ADDR_W      = 6,
  parameter  int DATA_W      = 24,
  parameter  int IMPL_REGS   = 48,
  parameter  int SYNC_STAGES = 2,
  localparam int FRAME_LEN   = ADDR_W + DATA_W + 2,
  localparam int CNT_W       = $clog2(FRAME_LEN + 1),
  localparam int FLAT_W      = IMPL_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_clk,
  input  logic              spi_sel,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [FLAT_W-1:0] reg_flat
);

  logic [2:0]        pins_s;
  logic              sel_s;
  logic              mosi_s;
  logic              sclk_s;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;
  logic              wr_en;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic              miso_q;
  logic [CNT_W-1:0]  bit_cnt;

  spi_ctl_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (3)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .raw ({spi_sel, spi_mosi, spi_clk}),
    .sync(pins_s)
  );

  assign sel_s  = pins_s[2];
  assign mosi_s = pins_s[1];
  assign sclk_s = pins_s[0];

  spi_ctl_frame #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_frame (
    .clk    (clk),
    .rst    (rst),
    .sel_s  (sel_s),
    .mosi_s (mosi_s),
    .sclk_s (sclk_s),
    .raddr  (raddr),
    .rdata  (rdata),
    .wr_en  (wr_en),
    .waddr  (waddr),
    .wdata  (wdata),
    .miso_q (miso_q),
    .miso_oe(spi_miso_oe),
    .bit_cnt(bit_cnt)
  );

  spi_ctl_bank #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IMPL_REGS(IMPL_REGS)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .waddr   (waddr),
    .wdata   (wdata),
    .raddr   (raddr),
    .rdata   (rdata),
    .reg_flat(reg_flat)
  );

  assign spi_miso = spi_miso_oe ? miso_q : 1'bz;

endmodule

// File: rtl/spi_ctl_regfile_chk.sv
module spi_ctl_regfile_chk #(
  parameter  int ADDR_W    = 6,
  parameter  int DATA_W    = 24,
  parameter  int IMPL_REGS = 48,
  localparam int FRAME_LEN = ADDR_W + DATA_W + 2,
  localparam int CNT_W     = $clog2(FRAME_LEN + 1),
  localparam int HDR_LEN   = ADDR_W + 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        sel_s,
  input logic                        miso_oe,
  input logic                        miso_q,
  input logic [CNT_W-1:0]            bit_cnt,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           waddr,
  input logic [IMPL_REGS*DATA_W-1:0] reg_flat
);

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!miso_oe && reg_flat == '0));

  a_r2_oe_off: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> !miso_oe);

  a_r2_oe_on: assert property (@(posedge clk) disable iff (rst)
    sel_s |=> miso_oe);

  a_r5_header_zero: assert property (@(posedge clk) disable iff (rst)
    (int'(bit_cnt) < HDR_LEN) |-> !miso_q);

  a_r8_count_cap: assert property (@(posedge clk) disable iff (rst)
    int'(bit_cnt) <= FRAME_LEN);

  a_r3_commit_last: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (int'(bit_cnt) == FRAME_LEN));

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> $stable(reg_flat));

  a_r9_unimpl_stable: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(waddr) >= IMPL_REGS) |=> $stable(reg_flat));

endmodule

bind spi_ctl_regfile spi_ctl_regfile_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .IMPL_REGS(IMPL_REGS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_s   (sel_s),
  .miso_oe (spi_miso_oe),
  .miso_q  (miso_q),
  .bit_cnt (bit_cnt),
  .wr_en   (wr_en),
  .waddr   (waddr),
  .reg_flat(reg_flat)
);

// File: tb/test_spi_ctl_regfile.sv
module test_spi_ctl_regfile;

  localparam int IMPL = 48;
  localparam int DW   = 24;
  localparam int FW   = IMPL * DW;
  localparam int H    = 8;   // system clocks per serial half-period
  localparam int NV   = 13;

  // frame layout: {wr, addr[5:0], separator, data[23:0]}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 6'd0,  1'b0, 24'hA5A5A5},
    {1'b1, 6'd63, 1'b0, 24'hFFFFFF},
    {1'b1, 6'd47, 1'b1, 24'h123456},
    {1'b1, 6'd1,  1'b0, 24'h800001},
    {1'b0, 6'd0,  1'b0, 24'h000000},
    {1'b0, 6'd47, 1'b1, 24'hFFFFFF},
    {1'b0, 6'd63, 1'b0, 24'h000000},
    {1'b1, 6'd0,  1'b1, 24'h5A5A5A},
    {1'b0, 6'd1,  1'b0, 24'h0F0F0F},
    {1'b0, 6'd0,  1'b1, 24'h000000},
    {1'b1, 6'd50, 1'b0, 24'h777777},
    {1'b0, 6'd50, 1'b0, 24'h000000},
    {1'b0, 6'd5,  1'b0, 24'h000000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_clk = 1'b0;
  logic          spi_sel = 1'b0;
  logic          spi_mosi = 1'b0;
  wire           spi_miso;
  logic          spi_miso_oe;
  logic [FW-1:0] reg_flat;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [64];

  always #2 clk = ~clk;

  spi_ctl_regfile i_spi_ctl_regfile (
    .clk        (clk),
    .rst        (rst),
    .spi_clk    (spi_clk),
    .spi_sel    (spi_sel),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso),
    .spi_miso_oe(spi_miso_oe),
    .reg_flat   (reg_flat)
  );

  function automatic logic [FW-1:0] model_flat();
    logic [FW-1:0] f = '0;
    for (int i = 0; i < IMPL; i++) f[i*DW +: DW] = model[i];
    return f;
  endfunction

  task automatic check(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] fr, input int nbits, input int extra,
                           output logic [DW-1:0] got, output int hdr_bad, output int oe_bad);
    got = '0; hdr_bad = 0; oe_bad = 0;
    @(negedge clk);
    spi_sel = 1'b1;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = fr[31-i];
      spi_clk  = 1'b0;
      repeat (H) @(negedge clk);
      if (spi_miso_oe !== 1'b1) oe_bad++;
      if (i < 8) begin
        if (spi_miso !== 1'b0) hdr_bad++;
      end else begin
        got = {got[DW-2:0], spi_miso};
      end
      spi_clk = 1'b1;
      repeat (H) @(negedge clk);
    end
    for (int e = 0; e < extra; e++) begin
      spi_mosi = 1'b1;
      spi_clk  = 1'b0;
      repeat (H) @(negedge clk);
      spi_clk = 1'b1;
      repeat (H) @(negedge clk);
    end
    spi_clk = 1'b0;
    repeat (H) @(negedge clk);
    spi_sel  = 1'b0;
    spi_mosi = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    logic [DW-1:0] exp_rd;
    int hb, ob;
    for (int i = 0; i < 64; i++) model[i] = '0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 flat after reset", reg_flat, '0);
    check("R1 oe after reset", FW'(spi_miso_oe), '0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] fr = VEC[v];
      int a = int'(fr[30:25]);
      exp_rd = (a < IMPL) ? model[a] : '0;
      run_frame(fr, 32, 0, got, hb, ob);
      check("R2 oe high while selected", FW'(ob), '0);
      check("R2 oe low after deselect", FW'(spi_miso_oe), '0);
      check("R5 header bits zero", FW'(hb), '0);
      if (!fr[31]) begin
        // R4 read data, R6 separator ignored, R9 unimplemented reads zero
        check($sformatf("R4 R6 R9 read addr %0d", a), FW'(got), FW'(exp_rd));
      end else if (a < IMPL) begin
        model[a] = fr[23:0];
      end
      // R3 write lands in slice; R9 unimplemented write has no effect
      check($sformatf("R3 R9 flat after frame %0d", v), reg_flat, model_flat());
    end

    // R7: abort after 20 bits, write discarded
    run_frame({1'b1, 6'd3, 1'b0, 24'hABCDEF}, 20, 0, got, hb, ob);
    check("R7 abort at 20 bits", reg_flat, model_flat());
    // R7: abort after 31 bits
    run_frame({1'b1, 6'd2, 1'b0, 24'h13579B}, 31, 0, got, hb, ob);
    check("R7 abort at 31 bits", reg_flat, model_flat());
    // R7: next frame decodes normally
    run_frame({1'b0, 6'd3, 1'b0, 24'h000000}, 32, 0, got, hb, ob);
    check("R7 fresh read after abort", FW'(got), '0);
    run_frame({1'b1, 6'd2, 1'b0, 24'h2468AC}, 32, 0, got, hb, ob);
    model[2] = 24'h2468AC;
    check("R7 fresh write after abort", reg_flat, model_flat());

    // R8: extra clocks after 32 bits ignored
    run_frame({1'b1, 6'd4, 1'b0, 24'h0F0F0F}, 32, 3, got, hb, ob);
    model[4] = 24'h0F0F0F;
    check("R8 extra clocks ignored", reg_flat, model_flat());
    run_frame({1'b0, 6'd4, 1'b0, 24'h000000}, 32, 2, got, hb, ob);
    check("R8 read with extra clocks", FW'(got), FW'(24'h0F0F0F));

    // R1: reset clears loaded registers
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 64; i++) model[i] = '0;
    check("R1 flat after second reset", reg_flat, model_flat());
    run_frame({1'b0, 6'd0, 1'b0, 24'h000000}, 32, 0, got, hb, ob);
    check("R1 read zero after reset", FW'(got), '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule